// File: doc/BRIEF.md
# Switch Processor Access Port

This block is the host side of a time-slot switch. A processor reaches it over a plain parallel bus: chip select, data strobe, a read/write line, six address lines and eight data lines in each direction. The block answers with an acknowledge. It holds the switch's control byte. It also opens a 32-byte window onto one stream bank of the switch memories: the sample store, the low connection store and the high connection store.

The memories themselves belong to the serial switching engine, which has first claim on them. The block places one pending request on a memory bus and waits for the engine to hand it a free slot through `grant_i`. Because of this, the acknowledge arrives after a variable number of cycles. A wait counter caps that delay: once the cap is reached the block marks its request urgent and completes it regardless of the grant. The acknowledge stays up, with read data held, until the processor drops the strobe. One strobe gives exactly one access.

The control byte sets up the window. Bits 2..0 pick the stream bank and bits 4..3 pick the memory. Bit 7 turns on split mode, in which reads and writes go to different memories. Bit 6 is the global processor-output enable, which is passed to the switching engine.

Top module: `tsi_cpu_port`

## Requirements
- R1: After reset `ack_o`, `mem_req_o` and `proc_en_o` are 0, and a read of the control byte returns 0.
- R2: An access with address bit 5 = 0 and bits 1..0 = 00 reaches the control byte, whatever bits 4..2 hold. It makes no memory request, and `ack_o` is high at the first sample after the clock edge that sees the strobe.
- R3: An access with address bit 5 = 0 and bits 1..0 not 00 is unmapped. A read returns 0, a write leaves the control byte unchanged, and the access is acknowledged with no memory request.
- R4: With address bit 5 = 1, the request carries `mem_addr_o` = {control bits 2..0, address bits 4..0} and `mem_sel_o` = control bits 4..3. The codes are 01 for the sample store, 10 for the low connection store and 11 for the high connection store.
- R5: Memory code 00 is reserved. A window access under it makes no request, reads 0 and is acknowledged one cycle after the strobe is seen.
- R6: With control bit 7 set, window reads use code 01 and window writes use code 10, whatever bits 4..3 hold.
- R7: The sample store cannot be written from this port. A window write that resolves to code 01 makes no request and is still acknowledged.
- R8: A pending request holds its select, address, write flag and write data unchanged. It completes only at a clock edge where `grant_i` or `mem_urgent_o` is high. A read takes `mem_rdata_i` at that edge, and `ack_o` rises right after it.
- R9: After WAIT_MAX cycles without a grant, `mem_urgent_o` is raised and the access completes at that edge. So `ack_o` is visible no later than WAIT_MAX+2 samples after the strobe.
- R10: `ack_o` and `rdata_o` hold steady while the strobe stays active, and no new access starts. `ack_o` drops at the first edge that sees the strobe released.
- R11: `proc_en_o` follows control bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| strobe_i | input | 1 | Data strobe, active high |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 6 | Bit 5 picks window (1) or register space (0); bits 4..0 are the channel |
| wdata_i | input | 8 | Write data from the processor |
| rdata_o | output | 8 | Read data, valid while `ack_o` is high, else 0 |
| ack_o | output | 1 | Access acknowledge |
| proc_en_o | output | 1 | Global processor-output enable (control bit 6) |
| mem_req_o | output | 1 | Memory request pending |
| mem_we_o | output | 1 | Pending request is a write |
| mem_sel_o | output | 2 | Memory code of the request |
| mem_addr_o | output | 8 | Stream bank and channel of the request |
| mem_wdata_o | output | 8 | Write data of the request |
| mem_rdata_i | input | 8 | Memory read data, sampled at the completing edge |
| grant_i | input | 1 | Memory slot free for this port |
| mem_urgent_o | output | 1 | Wait limit reached; request completes this cycle |

## Verification
The hardest case to reach is the forced completion. It needs a request that is starved for exactly WAIT_MAX cycles, so that the urgent flag appears and the read data is still taken at that edge. The bench's access task takes a grant delay in cycles. Given a delay far beyond the limit, it never raises `grant_i`, and the measured acknowledge latency must equal WAIT_MAX+2. The same task holds the strobe for several cycles after the acknowledge, to show that the held data does not change and that no second request appears.

// File: rtl/tsi_port_pkg.sv
package tsi_port_pkg;
  typedef enum logic [1:0] {
    MSEL_RSVD    = 2'b00,
    MSEL_DATA    = 2'b01,
    MSEL_CONN_LO = 2'b10,
    MSEL_CONN_HI = 2'b11
  } msel_e;

  typedef enum logic [1:0] {
    TGT_CTRL = 2'b00,
    TGT_NONE = 2'b01,
    TGT_MEM  = 2'b10
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_ACK  = 2'b10
  } st_e;
endpackage

// File: rtl/tsi_addr_decode.sv
module tsi_addr_decode import tsi_port_pkg::*; #(
  parameter int CH_W     = 5,
  parameter int STREAM_W = 3,
  localparam int MA_W    = STREAM_W + CH_W
) (
  input  logic [CH_W:0]     addr_i,
  input  logic              rd_i,
  input  logic              split_i,
  input  logic [1:0]        msel_fld_i,
  input  logic [STREAM_W-1:0] stream_i,
  output tgt_e              tgt_o,
  output msel_e             msel_o,
  output logic [MA_W-1:0]   maddr_o
);
  always_comb begin
    msel_o = msel_e'(msel_fld_i);
    // split mode: reads from sample store, writes to low connection store
    if (split_i) msel_o = rd_i ? MSEL_DATA : MSEL_CONN_LO;

    if (!addr_i[CH_W]) begin
      tgt_o = (addr_i[1:0] == 2'b00) ? TGT_CTRL : TGT_NONE;
    end else if (msel_o == MSEL_RSVD || (msel_o == MSEL_DATA && !rd_i)) begin
      tgt_o = TGT_NONE;
    end else begin
      tgt_o = TGT_MEM;
    end
  end

  assign maddr_o = {stream_i, addr_i[CH_W-1:0]};
endmodule

// File: rtl/tsi_ctrl_reg.sv
module tsi_ctrl_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/tsi_access_fsm.sv
module tsi_access_fsm import tsi_port_pkg::*; #(
  parameter int DATA_W   = 8,
  parameter int MA_W     = 8,
  parameter int WAIT_MAX = 8,
  localparam int CNT_W   = $clog2(WAIT_MAX + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  tgt_e              tgt_i,
  input  logic              rd_i,
  input  msel_e             msel_i,
  input  logic [MA_W-1:0]   maddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ctrl_q_i,
  input  logic              grant_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              ctrl_we_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_sel_o,
  output logic [MA_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_urgent_o
);
  st_e               st_q;
  logic              rd_q;
  msel_e             msel_q;
  logic [MA_W-1:0]   maddr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [CNT_W-1:0]  wcnt_q;
  logic              start, urgent, complete;

  assign start     = (st_q == ST_IDLE) && active_i;
  assign ctrl_we_o = start && (tgt_i == TGT_CTRL) && !rd_i;
  assign urgent    = (st_q == ST_REQ) && (wcnt_q == CNT_W'(WAIT_MAX));
  assign complete  = (st_q == ST_REQ) && (grant_i || urgent);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rd_q    <= 1'b0;
      msel_q  <= MSEL_RSVD;
      maddr_q <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wcnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (active_i) begin
          rd_q    <= rd_i;
          msel_q  <= msel_i;
          maddr_q <= maddr_i;
          wdata_q <= wdata_i;
          wcnt_q  <= '0;
          unique case (tgt_i)
            TGT_MEM: begin
              st_q    <= ST_REQ;
              rdata_q <= '0;
            end
            TGT_CTRL: begin
              st_q    <= ST_ACK;
              rdata_q <= rd_i ? ctrl_q_i : '0;
            end
            default: begin
              st_q    <= ST_ACK;
              rdata_q <= '0;
            end
          endcase
        end
        ST_REQ: begin
          if (complete) begin
            st_q    <= ST_ACK;
            rdata_q <= rd_q ? mem_rdata_i : '0;
          end else begin
            wcnt_q  <= wcnt_q + 1'b1;
          end
        end
        ST_ACK: if (!active_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o        = (st_q == ST_ACK);
  assign rdata_o      = ack_o ? rdata_q : '0;
  assign mem_req_o    = (st_q == ST_REQ);
  assign mem_we_o     = mem_req_o && !rd_q;
  assign mem_sel_o    = msel_q;
  assign mem_addr_o   = maddr_q;
  assign mem_wdata_o  = wdata_q;
  assign mem_urgent_o = urgent;
endmodule

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port import tsi_port_pkg::*; #(
  parameter int DATA_W   = 8,
  parameter int CH_W     = 5,
  parameter int STREAM_W = 3,
  parameter int WAIT_MAX = 8,
  localparam int MA_W    = STREAM_W + CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              strobe_i,
  input  logic              rd_i,
  input  logic [CH_W:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic              proc_en_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_sel_o,
  output logic [MA_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              grant_i,
  output logic              mem_urgent_o
);
  localparam int SPLIT_BIT = DATA_W - 1;
  localparam int PE_BIT    = DATA_W - 2;

  logic [DATA_W-1:0] ctrl_q;
  logic              ctrl_we;
  tgt_e              tgt;
  msel_e             msel;
  logic [MA_W-1:0]   maddr;

  tsi_addr_decode #(.CH_W(CH_W), .STREAM_W(STREAM_W)) u_dec (
    .addr_i    (addr_i),
    .rd_i      (rd_i),
    .split_i   (ctrl_q[SPLIT_BIT]),
    .msel_fld_i(ctrl_q[STREAM_W+1:STREAM_W]),
    .stream_i  (ctrl_q[STREAM_W-1:0]),
    .tgt_o     (tgt),
    .msel_o    (msel),
    .maddr_o   (maddr)
  );

  tsi_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctrl_we),
    .wdata_i(wdata_i),
    .q_o    (ctrl_q)
  );

  tsi_access_fsm #(.DATA_W(DATA_W), .MA_W(MA_W), .WAIT_MAX(WAIT_MAX)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (cs_i && strobe_i),
    .tgt_i       (tgt),
    .rd_i        (rd_i),
    .msel_i      (msel),
    .maddr_i     (maddr),
    .wdata_i     (wdata_i),
    .ctrl_q_i    (ctrl_q),
    .grant_i     (grant_i),
    .mem_rdata_i (mem_rdata_i),
    .ctrl_we_o   (ctrl_we),
    .ack_o       (ack_o),
    .rdata_o     (rdata_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_sel_o   (mem_sel_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_urgent_o(mem_urgent_o)
  );

  assign proc_en_o = ctrl_q[PE_BIT];
endmodule

// File: rtl/tsi_port_chk.sv
module tsi_port_chk #(
  parameter int DATA_W   = 8,
  parameter int MA_W     = 8,
  parameter int WAIT_MAX = 8,
  localparam int CW      = $clog2(WAIT_MAX + 2) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              strobe_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              ack_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [1:0]        mem_sel_o,
  input logic [MA_W-1:0]   mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              grant_i,
  input logic              mem_urgent_o
);
  logic [CW-1:0] req_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        req_run <= '0;
    else if (mem_req_o) req_run <= req_run + 1'b1;
    else                req_run <= '0;
  end

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !grant_i && !mem_urgent_o |=> mem_req_o && $stable(mem_sel_o)
      && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R8
  req_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && (grant_i || mem_urgent_o) |=> ack_o && !mem_req_o);

  // R9
  wait_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> req_run <= CW'(WAIT_MAX));

  // R9
  urgent_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_urgent_o |-> mem_req_o && req_run == CW'(WAIT_MAX));

  // R7
  no_data_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_sel_o != 2'b01);

  // R5
  no_rsvd_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_sel_o != 2'b00);

  // R10
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && cs_i && strobe_i |=> ack_o && $stable(rdata_o));

  // R10
  ack_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !mem_req_o);
endmodule

bind tsi_cpu_port tsi_port_chk #(.DATA_W(DATA_W), .MA_W(MA_W), .WAIT_MAX(WAIT_MAX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_i        (cs_i),
  .strobe_i    (strobe_i),
  .rdata_o     (rdata_o),
  .ack_o       (ack_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_sel_o   (mem_sel_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .grant_i     (grant_i),
  .mem_urgent_o(mem_urgent_o)
);

// File: tb/tsi_cpu_port_test.sv
`timescale 1ns/1ps
module tsi_cpu_port_test;
  localparam int WAIT_MAX = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, strobe = 1'b0, rd = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ack, proc_en, mem_req, mem_we, urgent;
  logic [1:0] mem_sel;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       grant = 1'b0;

  logic [7:0] dm [256];
  logic [7:0] cml[256];
  logic [7:0] cmh[256];
  int req_cycles = 0;
  int urgent_seen = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tsi_cpu_port #(.WAIT_MAX(WAIT_MAX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .strobe_i(strobe), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack),
    .proc_en_o(proc_en), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_sel_o(mem_sel), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .grant_i(grant), .mem_urgent_o(urgent)
  );

  // memory model owned by the switching engine
  always_comb begin
    case (mem_sel)
      2'b01:   mem_rdata = dm[mem_addr];
      2'b10:   mem_rdata = cml[mem_addr];
      2'b11:   mem_rdata = cmh[mem_addr];
      default: mem_rdata = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    if (rst_n && mem_req) begin
      req_cycles <= req_cycles + 1;
      if (urgent) urgent_seen <= urgent_seen + 1;
      if (mem_we && (grant || urgent)) begin
        case (mem_sel)
          2'b01: dm[mem_addr]  <= mem_wdata;
          2'b10: cml[mem_addr] <= mem_wdata;
          2'b11: cmh[mem_addr] <= mem_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] dm_init(int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one strobe: grant raised gdelay samples after the strobe, ack held hold cycles
  task automatic access(input logic r, input logic [5:0] a, input logic [7:0] d,
                        input int gdelay, input int hold,
                        output logic [7:0] rdv, output int lat);
    int cyc = 0;
    @(negedge clk);
    cs = 1'b1; strobe = 1'b1; rd = r; addr = a; wdata = d; grant = 1'b0;
    while (cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (ack) break;
      if (cyc == gdelay) grant = 1'b1;
    end
    grant = 1'b0;
    lat = cyc;
    rdv = rdata;
    if (hold > 0) begin
      int bad = 0;
      int rq = req_cycles;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        if (!ack || rdata !== rdv) bad++;
      end
      check("R10 ack/data held", 32'(bad), 32'd0);
      check("R10 no new request while held", 32'(req_cycles - rq), 32'd0);
    end
    cs = 1'b0; strobe = 1'b0;
    @(negedge clk);
    check("R10 ack drops after release", 32'(ack), 32'd0);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    logic [7:0] rv; int l;
    access(1'b0, 6'b000000, v, 1, 0, rv, l);
  endtask

  task automatic t_reset;
    logic [7:0] rv; int l;
    check("R1 ack_o", 32'(ack), 32'd0);
    check("R1 mem_req_o", 32'(mem_req), 32'd0);
    check("R1 proc_en_o", 32'(proc_en), 32'd0);
    access(1'b1, 6'b000000, 8'h00, 1, 0, rv, l);
    check("R1 control read", 32'(rv), 32'd0);
  endtask

  task automatic t_ctrl;
    logic [7:0] rv; int l; int rq = req_cycles;
    access(1'b0, 6'b011100, 8'h4A, 1000, 0, rv, l);
    check("R2 write latency", 32'(l), 32'd1);
    access(1'b1, 6'b010000, 8'h00, 1000, 0, rv, l);
    check("R2 read back", 32'(rv), 32'h4A);
    check("R2 read latency", 32'(l), 32'd1);
    check("R2 no memory request", 32'(req_cycles - rq), 32'd0);
    check("R11 proc_en_o set", 32'(proc_en), 32'd1);
  endtask

  task automatic t_unmapped;
    logic [7:0] rv; int l; int rq = req_cycles;
    access(1'b0, 6'b000001, 8'hFF, 1000, 0, rv, l);
    check("R3 write latency", 32'(l), 32'd1);
    access(1'b1, 6'b000010, 8'h00, 1000, 0, rv, l);
    check("R3 unmapped read", 32'(rv), 32'd0);
    access(1'b1, 6'b000000, 8'h00, 1000, 0, rv, l);
    check("R3 control unchanged", 32'(rv), 32'h4A);
    check("R3 no memory request", 32'(req_cycles - rq), 32'd0);
  endtask

  task automatic t_window;
    logic [7:0] rv; int l;
    wr_ctrl(8'h15);  // conn low, stream 5
    check("R11 proc_en_o cleared", 32'(proc_en), 32'd0);
    access(1'b0, 6'b100111, 8'h3C, 3, 0, rv, l);
    check("R8 write latency", 32'(l), 32'd4);
    check("R4 conn low written", 32'(cml[5*32+7]), 32'h3C);
    wr_ctrl(8'h1B);  // conn high, stream 3
    access(1'b0, 6'b111111, 8'h81, 1, 0, rv, l);
    check("R4 conn high written", 32'(cmh[3*32+31]), 32'h81);
    access(1'b1, 6'b111111, 8'h00, 2, 4, rv, l);
    check("R4 conn high read", 32'(rv), 32'h81);
    check("R8 read latency", 32'(l), 32'd3);
    wr_ctrl(8'h0A);  // sample store, stream 2
    access(1'b1, 6'b100100, 8'h00, 5, 0, rv, l);
    check("R4 sample store read", 32'(rv), 32'(dm_init(2*32+4)));
    check("R8 grant latency", 32'(l), 32'd6);
  endtask

  task automatic t_reserved;
    logic [7:0] rv; int l; int rq = req_cycles;
    wr_ctrl(8'h02);
    access(1'b1, 6'b100011, 8'h00, 1000, 0, rv, l);
    check("R5 reserved read", 32'(rv), 32'd0);
    check("R5 reserved latency", 32'(l), 32'd1);
    access(1'b0, 6'b100011, 8'h77, 1000, 0, rv, l);
    check("R5 reserved write latency", 32'(l), 32'd1);
    check("R5 no memory request", 32'(req_cycles - rq), 32'd0);
  endtask

  task automatic t_dm_write;
    logic [7:0] rv; int l; int rq;
    wr_ctrl(8'h0A);
    rq = req_cycles;
    access(1'b0, 6'b100100, 8'h11, 1000, 0, rv, l);
    check("R7 write acknowledged", 32'(l), 32'd1);
    check("R7 no memory request", 32'(req_cycles - rq), 32'd0);
    access(1'b1, 6'b100100, 8'h00, 1, 0, rv, l);
    check("R7 sample store unchanged", 32'(rv), 32'(dm_init(2*32+4)));
  endtask

  task automatic t_split;
    logic [7:0] rv; int l;
    logic [7:0] hi_before = cmh[1*32+9];
    wr_ctrl(8'h99);  // split, field says conn high, stream 1
    access(1'b0, 6'b101001, 8'h5A, 2, 0, rv, l);
    check("R6 write to conn low", 32'(cml[1*32+9]), 32'h5A);
    check("R6 conn high untouched", 32'(cmh[1*32+9]), 32'(hi_before));
    access(1'b1, 6'b101001, 8'h00, 2, 0, rv, l);
    check("R6 read from sample store", 32'(rv), 32'(dm_init(1*32+9)));
  endtask

  task automatic t_bound;
    logic [7:0] rv; int l; int us = urgent_seen;
    wr_ctrl(8'h15);
    access(1'b1, 6'b100111, 8'h00, 1000, 3, rv, l);
    check("R9 bounded latency", 32'(l), 32'(WAIT_MAX + 2));
    check("R9 urgent raised once", 32'(urgent_seen - us), 32'd1);
    check("R9 forced read data", 32'(rv), 32'h3C);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      dm[i]  = dm_init(i);
      cml[i] = 8'h00;
      cmh[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_unmapped();
    t_window();
    t_reserved();
    t_dm_write();
    t_split();
    t_bound();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule